// File: doc/BRIEF.md
# DMA Channel Context Identifier Register

This block holds the context identifier of one DMA channel. The identifier is 32 bits wide and is reached through a coprocessor-style register access port, which has separate read and write strobes and a flag that tells whether the access comes from privileged mode. Software running in privileged mode loads the identifier when it sets up the channel. The lowest byte is driven out all the time as the address-space identifier (ASID). The translation logic uses that ASID to keep the virtual address maps of different processes apart.

The register has two guards. The first depends on the channel state: a write is dropped without any error while the channel is queued or running, and also in the reserved state encoding. The second depends on privilege: any access made in user mode, read or write, raises an undefined-instruction trap in the same cycle, and the register does not change. The bit that marks a channel as user-accessible is also held here. It is loaded only in the same accepted write that loads the identifier. A privileged read returns all 32 bits, so the value can be saved when the context changes and written back later.

Top module: `dma_ctxid_reg`

## Requirements
- R1: After a synchronous active-high reset, the stored identifier is 0, `asid` is 0, `chan_user` is 0, `trap` is 0 and `rd_data` is 0.
- R2: A write with `wr_en`=1, `priv`=1 and `ch_state`=0 (idle) stores `wr_data` at the next rising clock edge. The new value can be seen on `asid` and through reads from the cycle after that edge.
- R3: `asid` always equals bits [7:0] of the stored identifier.
- R4: A write while `ch_state` is 1 (queued), 2 (running) or 3 (reserved, treated as busy) leaves the identifier and `chan_user` unchanged, and `trap` stays 0.
- R5: A read with `rd_en`=1 and `priv`=1 returns the full stored identifier on `rd_data` in the same cycle, whatever the channel state. At all other times `rd_data` is 0.
- R6: An access with `priv`=0 and either strobe high drives `trap` to 1 in that same cycle. Such an access leaves the identifier and `chan_user` unchanged, and `rd_data` stays 0.
- R7: `trap` is 0 in every cycle that has no user-mode access, including all privileged accesses.
- R8: `chan_user` takes `u_wr_val` only when `u_wr_en`=1 arrives with an accepted context write. A `u_wr_en` without `wr_en`, or with a write that is not accepted, leaves `chan_user` unchanged. An accepted write with `u_wr_en`=0 keeps `chan_user`.
- R9: A value read out in privileged mode and later written back while idle restores the identifier and `asid` exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| priv | input | 1 | 1 = privileged access, 0 = user access |
| ch_state | input | 2 | Channel state: 0 idle, 1 queued, 2 running, 3 reserved |
| u_wr_en | input | 1 | Write the user-accessible bit together with this context write |
| u_wr_val | input | 1 | New value of the user-accessible bit |
| rd_data | output | 32 | Read data (0 unless this is a privileged read) |
| asid | output | 8 | Address-space identifier, the low byte of the stored identifier |
| chan_user | output | 1 | User-accessible bit of the channel |
| trap | output | 1 | Undefined-instruction trap, pulses with a user-mode access |

## Verification
`trap` and `rd_data` are combinational, so they are due in the same cycle as the access. The bench samples them one nanosecond after it drives the inputs, with the clock still low. `asid`, `chan_user` and read-back data change at the rising edge that ends an accepted write, so the bench checks them one nanosecond after that edge. Each ignored or trapped write is followed by a check of `asid` and `chan_user`, and the directed tests also read the identifier back. This confirms at the ports that the register kept its value.

// File: rtl/dma_ctxid_pkg.sv
package dma_ctxid_pkg;

    parameter int CTX_W  = 32;
    parameter int ASID_W = 8;

    typedef enum logic [1:0] {
        CH_IDLE    = 2'd0,
        CH_QUEUED  = 2'd1,
        CH_RUNNING = 2'd2,
        CH_RSVD    = 2'd3
    } ch_state_e;

    // Result of decoding one access cycle
    typedef struct packed {
        logic commit;   // write the identifier this cycle
        logic take_u;   // write the user-accessible bit with it
        logic rd_ok;    // drive the stored value on the read bus
        logic trap;     // user-mode access: undefined-instruction trap
    } acc_dec_t;

    function automatic logic ch_writable(input ch_state_e s);
        return (s == CH_IDLE);
    endfunction

endpackage

// File: rtl/dma_ctxid_access.sv
module dma_ctxid_access
    import dma_ctxid_pkg::*;
(
    input  logic      rd_en,
    input  logic      wr_en,
    input  logic      priv,
    input  ch_state_e ch_state,
    input  logic      u_wr_en,
    output acc_dec_t  dec
);

    logic any_acc;

    always_comb begin
        any_acc    = rd_en | wr_en;
        dec        = '0;
        dec.trap   = any_acc & ~priv;
        dec.rd_ok  = rd_en & priv;
        dec.commit = wr_en & priv & ch_writable(ch_state);
        dec.take_u = dec.commit & u_wr_en;
    end

endmodule

// File: rtl/dma_ctxid_store.sv
module dma_ctxid_store
    import dma_ctxid_pkg::*;
#(
    parameter int W = 32
)(
    input  logic         clk,
    input  logic         rst,
    input  acc_dec_t     dec,
    input  logic [W-1:0] wr_data,
    input  logic         u_val,
    output logic [W-1:0] ctx_q,
    output logic         u_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '0;
            u_q   <= 1'b0;
        end else begin
            if (dec.commit) ctx_q <= wr_data;
            if (dec.take_u) u_q   <= u_val;
        end
    end

endmodule

// File: rtl/dma_ctxid_reg.sv
module dma_ctxid_reg
    import dma_ctxid_pkg::*;
#(
    parameter int DATA_W = dma_ctxid_pkg::CTX_W,
    parameter int AID_W  = dma_ctxid_pkg::ASID_W
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              priv,
    input  logic [1:0]        ch_state,
    input  logic              u_wr_en,
    input  logic              u_wr_val,
    output logic [DATA_W-1:0] rd_data,
    output logic [AID_W-1:0]  asid,
    output logic              chan_user,
    output logic              trap
);

    acc_dec_t          dec;
    ch_state_e         st;
    logic [DATA_W-1:0] ctx_q;

    assign st = ch_state_e'(ch_state);

    dma_ctxid_access u_acc (
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .priv    (priv),
        .ch_state(st),
        .u_wr_en (u_wr_en),
        .dec     (dec)
    );

    dma_ctxid_store #(.W(DATA_W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .dec    (dec),
        .wr_data(wr_data),
        .u_val  (u_wr_val),
        .ctx_q  (ctx_q),
        .u_q    (chan_user)
    );

    assign rd_data = dec.rd_ok ? ctx_q : '0;
    assign asid    = ctx_q[AID_W-1:0];
    assign trap    = dec.trap;

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ch_state != 2'd0) |=> ($stable(ctx_q) && $stable(chan_user))); // R4
    AST_USER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!priv && (wr_en || rd_en)) |=> ($stable(ctx_q) && $stable(chan_user))); // R6
    AST_IDLE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && priv && ch_state == 2'd0) |=> (asid == $past(wr_data[AID_W-1:0]))); // R2
    AST_UBIT_PAIRED: assert property (@(posedge clk) disable iff (rst)
        (u_wr_en && !wr_en) |=> $stable(chan_user)); // R8
    AST_TRAP_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        trap |-> (rd_data == '0)); // R6
    AST_PRIV_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
        (priv || !(rd_en || wr_en)) |-> !trap); // R7

endmodule

// File: tb/dma_ctxid_reg_tb.sv
`timescale 1ns/1ps
module dma_ctxid_reg_tb;

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic        pv;
        logic [1:0]  st;
        logic        uw;
        logic        uv;
        logic [31:0] wd;
        logic [31:0] ex_rd;
        logic        ex_tr;
        logic [7:0]  ex_asid;
        logic        ex_u;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b1,1'b1,2'd0,1'b1,1'b1,32'hA5A5_1234,32'h0,        1'b0,8'h34,1'b1,8'd2}, // R2 idle write with U
        '{1'b1,1'b0,1'b1,2'd0,1'b0,1'b0,32'h0,        32'hA5A5_1234,1'b0,8'h34,1'b1,8'd5}, // R5 privileged read
        '{1'b0,1'b1,1'b1,2'd1,1'b1,1'b0,32'hFFFF_FF00,32'h0,        1'b0,8'h34,1'b1,8'd4}, // R4 queued
        '{1'b0,1'b1,1'b1,2'd2,1'b0,1'b0,32'h0000_0011,32'h0,        1'b0,8'h34,1'b1,8'd4}, // R4 running
        '{1'b0,1'b1,1'b1,2'd3,1'b0,1'b0,32'h0000_0022,32'h0,        1'b0,8'h34,1'b1,8'd4}, // R4 reserved
        '{1'b0,1'b1,1'b0,2'd0,1'b1,1'b0,32'h0000_0077,32'h0,        1'b1,8'h34,1'b1,8'd6}, // R6 user write
        '{1'b1,1'b0,1'b0,2'd0,1'b0,1'b0,32'h0,        32'h0,        1'b1,8'h34,1'b1,8'd6}, // R6 user read
        '{1'b1,1'b1,1'b0,2'd0,1'b1,1'b0,32'h0000_0055,32'h0,        1'b1,8'h34,1'b1,8'd6}, // R6 user read+write
        '{1'b0,1'b0,1'b1,2'd0,1'b1,1'b0,32'h0,        32'h0,        1'b0,8'h34,1'b1,8'd8}, // R8 U strobe alone
        '{1'b0,1'b1,1'b1,2'd0,1'b0,1'b0,32'h0000_00C3,32'h0,        1'b0,8'hC3,1'b1,8'd8}, // R8 write keeps U
        '{1'b1,1'b0,1'b1,2'd2,1'b0,1'b0,32'h0,        32'h0000_00C3,1'b0,8'hC3,1'b1,8'd5}, // R5 read while running
        '{1'b0,1'b1,1'b1,2'd0,1'b1,1'b0,32'hDEAD_BE01,32'h0,        1'b0,8'h01,1'b0,8'd3}  // R3 low byte, U cleared
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        rd_en, wr_en, priv, u_wr_en, u_wr_val;
    logic [31:0] wr_data;
    logic [1:0]  ch_state;
    logic [31:0] rd_data;
    logic [7:0]  asid;
    logic        chan_user, trap;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] saved;

    always #2.5 clk = ~clk;

    dma_ctxid_reg u_dut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .priv(priv), .ch_state(ch_state), .u_wr_en(u_wr_en), .u_wr_val(u_wr_val),
        .rd_data(rd_data), .asid(asid), .chan_user(chan_user), .trap(trap)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_bus();
        rd_en = 0; wr_en = 0; priv = 1; u_wr_en = 0; u_wr_val = 0;
        wr_data = '0; ch_state = 2'd0;
    endtask

    // Drive after a falling edge, check combinational results, then registered ones after the edge
    task automatic access(input logic r, input logic w, input logic p, input logic [1:0] s,
                          input logic uw, input logic uv, input logic [31:0] d);
        @(negedge clk);
        rd_en = r; wr_en = w; priv = p; ch_state = s; u_wr_en = uw; u_wr_val = uv; wr_data = d;
        #1;
    endtask

    task automatic read_back(input string req, input logic [31:0] exp);
        access(1, 0, 1, 2'd0, 0, 0, 32'h0);
        check(req, "read back", rd_data, exp);
        check(req, "asid", {24'h0, asid}, {24'h0, exp[7:0]});
    endtask

    initial begin
        idle_bus();
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        @(negedge clk); #1;
        check("R1", "asid", {24'h0, asid}, 32'h0);
        check("R1", "chan_user", {31'h0, chan_user}, 32'h0);
        check("R1", "trap", {31'h0, trap}, 32'h0);
        check("R1", "rd_data idle", rd_data, 32'h0);
        read_back("R1", 32'h0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string rq;
            v  = VECS[i];
            rq = $sformatf("R%0d", v.req);
            access(v.rd, v.wr, v.pv, v.st, v.uw, v.uv, v.wd);
            check(rq, "trap", {31'h0, trap}, {31'h0, v.ex_tr});
            check(rq, "rd_data", rd_data, v.ex_rd);
            @(posedge clk); #1;
            idle_bus();
            check(rq, "asid after", {24'h0, asid}, {24'h0, v.ex_asid});
            check(rq, "chan_user after", {31'h0, chan_user}, {31'h0, v.ex_u});
        end

        // R7: privileged accesses never trap, no access no trap
        access(1, 1, 1, 2'd2, 0, 0, 32'h1);
        check("R7", "trap priv rw", {31'h0, trap}, 32'h0);
        access(0, 0, 0, 2'd0, 0, 0, 32'h0);
        check("R7", "trap no access", {31'h0, trap}, 32'h0);
        check("R5", "rd_data without read", rd_data, 32'h0);
        idle_bus();

        // R4 / R6: full read-back confirms rejected writes left all 32 bits alone
        read_back("R4", 32'hDEAD_BE01);
        access(0, 1, 1, 2'd1, 1, 1, 32'h1234_5678);
        access(0, 1, 0, 2'd0, 1, 1, 32'h8765_4321);
        check("R6", "trap pulse", {31'h0, trap}, 32'h1);
        read_back("R6", 32'hDEAD_BE01);
        check("R8", "U after rejected", {31'h0, chan_user}, 32'h0);

        // R9 save and restore
        read_back("R9", 32'hDEAD_BE01);
        saved = rd_data;
        access(0, 1, 1, 2'd0, 0, 0, 32'h0BAD_F00D);
        @(posedge clk); #1;
        read_back("R9", 32'h0BAD_F00D);
        access(0, 1, 1, 2'd0, 0, 0, saved);
        @(posedge clk); #1;
        read_back("R9", 32'hDEAD_BE01);

        // R1 reset from a loaded state
        access(0, 1, 1, 2'd0, 1, 1, 32'h0000_00FF);
        @(posedge clk); #1;
        check("R8", "U set", {31'h0, chan_user}, 32'h1);
        idle_bus();
        rst = 1;
        @(posedge clk); #1;
        rst = 0;
        check("R1", "asid after reset", {24'h0, asid}, 32'h0);
        check("R1", "U after reset", {31'h0, chan_user}, 32'h0);
        read_back("R1", 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule